// File: doc/BRIEF.md
# Execute-in-Place Serial Flash Read Controller

This block sits on an on-chip bus as a read-only slave and makes an external serial flash look like ordinary memory. A read that falls inside a fixed 1 MB bus window is turned into one serial flash read sequence. The sequence has up to four phases: an optional command byte, the flash address, a mode/dummy phase, and the returned data. Reads that miss the window finish at once with zero. The flash address is the offset into the window plus a programmable base, so the window can be moved anywhere in the flash.

The address, mode/dummy and data phases each have their own lane width (one, two or four data lines). The command byte always uses one line. The mode/dummy phase starts with a mode byte. When continuous-read entry is enabled, the activation byte is sent and later reads leave out the command byte. When it is disabled, the termination byte is sent and the flash returns to normal command-led reads. The serial clock runs at half the system clock, idles low and is sampled on its rising edge.

Top module: `xip_flash_reader`

## Requirements
- R1: A read whose bus address lies in [0x0008_0000, 0x0018_0000) starts a flash sequence. Any other address gets `rsp_done` in the cycle after acceptance with `rsp_data` = 0, and chip select never goes low for it.
- R2: The flash address equals bus address − 0x0008_0000 + `cfg_base` and is sent most significant bit first.
- R3: The address phase carries 4 bytes when `cfg_addr4` = 1 and the low 3 bytes when it is 0.
- R4: Lane encoding is 0 = single, 1 = dual, 2 or 3 = quad. Single mode drives on io[0] and samples io[1]. Dual mode uses io[1:0] and quad mode uses io[3:0]. On every clock the higher-numbered line carries the more significant bit. The command byte is always single. Output enables are set only for lanes being driven.
- R5: The mode/dummy phase lasts `cfg_md_clks` serial clocks. The mode byte is driven in the first 8/lanes of them, and all lines are released for the rest. A value of 0 removes the phase.
- R6: A sequence whose mode/dummy phase is present and `cfg_xip_en` = 1 sends `cfg_mode_act`. Every following read leaves out the command byte and starts with the address.
- R7: A sequence with a mode/dummy phase and `cfg_xip_en` = 0 sends `cfg_mode_term`. That sequence still omits the command if continuous mode was active, and the next read includes the command again.
- R8: `req_size` 0/1/2 returns 1/2/4 bytes. The first byte received lands in `rsp_data[7:0]`, the next bytes fill the next higher bytes, and unused upper bytes are zero.
- R9: Chip select is low for exactly two system cycles per serial clock of the sequence and high for at least two system cycles between sequences. The serial clock is low whenever chip select is high, and each high pulse lasts one system cycle.
- R10: `req_ready` is high only when the block is idle, and `rsp_done` is a single-cycle pulse per accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when both are high |
| req_addr | input | 32 | Bus byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Read result, valid with `rsp_done` |
| cfg_base | input | 32 | Remap base added to the window offset |
| cfg_addr4 | input | 1 | 1 selects four address bytes |
| cfg_cmd | input | 8 | Read command byte |
| cfg_addr_lanes | input | 2 | Address phase lane width |
| cfg_md_lanes | input | 2 | Mode/dummy phase lane width |
| cfg_data_lanes | input | 2 | Data phase lane width |
| cfg_md_clks | input | 4 | Mode/dummy phase length in serial clocks |
| cfg_xip_en | input | 1 | Select activation (1) or termination (0) mode byte |
| cfg_mode_act | input | 8 | Mode byte that enters continuous read |
| cfg_mode_term | input | 8 | Mode byte that leaves continuous read |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_io_o | output | 4 | Data line output values |
| spi_io_oe | output | 4 | Data line output enables |
| spi_io_i | input | 4 | Data line input values |

## Verification
The bench runs a flash model that records every rising serial clock edge and answers with computable data. It compares each driven clock, enable mask and lane value against a sequence built from the configuration. A controller that mixes up lane order, drives lines during dummy or data clocks, or sends the wrong number of address bytes fails the header comparison. It also shifts the data window and so returns wrong bytes. The continuous-read run enters, stays in, leaves and re-enters normal mode, so a controller that drops the command too early or too late is caught. Reads just outside both window edges and at the last in-window byte check the decode. A controller that let those through, or kept stale data, would show chip select activity or a non-zero result.

// File: rtl/xip_pkg.sv
package xip_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_MODE,
    ST_DATA,
    ST_DONE
  } xip_state_e;

  // log2 of the lane count: 0 single, 1 dual, 2 quad (3 also quad)
  function automatic logic [1:0] lane_lg(input logic [1:0] sel);
    case (sel)
      2'd0:    lane_lg = 2'd0;
      2'd1:    lane_lg = 2'd1;
      default: lane_lg = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/xip_addr_map.sv
module xip_addr_map #(
  parameter int          AW       = 32,
  parameter logic [31:0] WIN_BASE = 32'h0008_0000,
  parameter int          WIN_BITS = 20
) (
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] base,
  output logic          hit,
  output logic [AW-1:0] flash_addr
);
  logic [AW-1:0] offset;

  always_comb begin
    offset     = bus_addr - AW'(WIN_BASE);
    hit        = (offset[AW-1:WIN_BITS] == '0);
    flash_addr = offset + base;
  end
endmodule

// File: rtl/xip_lane_io.sv
module xip_lane_io (
  input  logic [1:0] lg,
  input  logic       drive,
  input  logic [3:0] tx,
  input  logic [3:0] io_i,
  output logic [3:0] io_o,
  output logic [3:0] io_oe,
  output logic [3:0] rx_bits
);
  always_comb begin
    case (lg)
      2'd0: begin
        io_o    = {3'b000, tx[3]};
        io_oe   = drive ? 4'b0001 : 4'b0000;
        rx_bits = {3'b000, io_i[1]};
      end
      2'd1: begin
        io_o    = {2'b00, tx[3:2]};
        io_oe   = drive ? 4'b0011 : 4'b0000;
        rx_bits = {2'b00, io_i[1:0]};
      end
      default: begin
        io_o    = tx;
        io_oe   = drive ? 4'b1111 : 4'b0000;
        rx_bits = io_i;
      end
    endcase
  end
endmodule

// File: rtl/xip_rx_pack.sv
module xip_rx_pack (
  input  logic [31:0] stream,
  input  logic [1:0]  size,
  output logic [31:0] data
);
  // stream holds the received bytes first-byte-most-significant
  always_comb begin
    case (size)
      2'd0:    data = {24'h0, stream[7:0]};
      2'd1:    data = {16'h0, stream[7:0], stream[15:8]};
      default: data = {stream[7:0], stream[15:8], stream[23:16], stream[31:24]};
    endcase
  end
endmodule

// File: rtl/xip_flash_reader.sv
module xip_flash_reader
  import xip_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [31:0] WIN_BASE = 32'h0008_0000,
  parameter int          WIN_BITS = 20,
  parameter int          MDW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  output logic          rsp_done,
  output logic [31:0]   rsp_data,
  input  logic [AW-1:0] cfg_base,
  input  logic          cfg_addr4,
  input  logic [7:0]    cfg_cmd,
  input  logic [1:0]    cfg_addr_lanes,
  input  logic [1:0]    cfg_md_lanes,
  input  logic [1:0]    cfg_data_lanes,
  input  logic [MDW-1:0] cfg_md_clks,
  input  logic          cfg_xip_en,
  input  logic [7:0]    cfg_mode_act,
  input  logic [7:0]    cfg_mode_term,
  output logic          spi_sclk,
  output logic          spi_cs_n,
  output logic [3:0]    spi_io_o,
  output logic [3:0]    spi_io_oe,
  input  logic [3:0]    spi_io_i
);
  localparam int SHW = 32;
  localparam int CW  = 6;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  xip_state_e     st_q, st_d;
  logic           ph_q, ph_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [SHW-1:0] sh_q, sh_d, rx_q, rx_d;
  logic [3:0]     mdrv_q, mdrv_d;
  logic           xip_q, xip_d;
  logic [1:0]     sz_q, sz_d;
  logic [AW-1:0]  fa_q, fa_d;
  logic [31:0]    rsp_q, rsp_d;
  logic           rsp_en;

  logic           hit;
  logic [AW-1:0]  map_fa;
  logic           active, drive;
  logic [1:0]     lg_a, lg_m, lg_dt, lg;
  logic [3:0]     rx_bits;
  logic [SHW-1:0] sh_shift, rx_shift;
  logic [31:0]    packed_data;
  logic [CW-1:0]  addr_clk, data_clk, data_bits;
  logic [7:0]     mode_byte;

  xip_addr_map #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS)) u_map (
    .bus_addr(req_addr), .base(cfg_base), .hit(hit), .flash_addr(map_fa)
  );

  xip_lane_io u_lanes (
    .lg(lg), .drive(drive), .tx(sh_q[SHW-1:SHW-4]), .io_i(spi_io_i),
    .io_o(spi_io_o), .io_oe(spi_io_oe), .rx_bits(rx_bits)
  );

  xip_rx_pack u_pack (.stream(rx_shift), .size(sz_q), .data(packed_data));

  function automatic logic [SHW-1:0] addr_word(input logic [AW-1:0] a, input logic four);
    return four ? a[31:0] : {a[23:0], 8'h00};
  endfunction

  always_comb begin
    active    = (st_q == ST_CMD) || (st_q == ST_ADDR) || (st_q == ST_MODE) || (st_q == ST_DATA);
    lg_a      = lane_lg(cfg_addr_lanes);
    lg_m      = lane_lg(cfg_md_lanes);
    lg_dt     = lane_lg(cfg_data_lanes);
    case (st_q)
      ST_ADDR: lg = lg_a;
      ST_MODE: lg = lg_m;
      ST_DATA: lg = lg_dt;
      default: lg = 2'd0;
    endcase
    drive     = (st_q == ST_CMD) || (st_q == ST_ADDR) || ((st_q == ST_MODE) && (mdrv_q != 4'd0));
    case (lg)
      2'd0:    begin sh_shift = sh_q << 1; rx_shift = (rx_q << 1) | {28'h0, rx_bits}; end
      2'd1:    begin sh_shift = sh_q << 2; rx_shift = (rx_q << 2) | {28'h0, rx_bits}; end
      default: begin sh_shift = sh_q << 4; rx_shift = (rx_q << 4) | {28'h0, rx_bits}; end
    endcase
    addr_clk  = (cfg_addr4 ? 6'd32 : 6'd24) >> lg_a;
    case (sz_q)
      2'd0:    data_bits = 6'd8;
      2'd1:    data_bits = 6'd16;
      default: data_bits = 6'd32;
    endcase
    data_clk  = data_bits >> lg_dt;
    mode_byte = cfg_xip_en ? cfg_mode_act : cfg_mode_term;
  end

  // next-state process
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    mdrv_d = mdrv_q;
    xip_d  = xip_q;
    sz_d   = sz_q;
    fa_d   = fa_q;
    rsp_d  = rsp_q;
    rsp_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          sz_d = req_size;
          fa_d = map_fa;
          ph_d = 1'b0;
          rx_d = '0;
          if (!hit) begin
            st_d   = ST_DONE;
            rsp_d  = '0;
            rsp_en = 1'b1;
          end else if (xip_q) begin
            st_d  = ST_ADDR;
            sh_d  = addr_word(map_fa, cfg_addr4);
            cnt_d = addr_clk;
          end else begin
            st_d  = ST_CMD;
            sh_d  = {cfg_cmd, 24'h0};
            cnt_d = 6'd8;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: begin
        ph_d = !ph_q;
        if (ph_q) begin
          sh_d  = sh_shift;
          cnt_d = cnt_q - 1'b1;
          if (st_q == ST_DATA) rx_d = rx_shift;
          if ((st_q == ST_MODE) && (mdrv_q != 4'd0)) mdrv_d = mdrv_q - 1'b1;
          if (cnt_q == 6'd1) begin
            case (st_q)
              ST_CMD: begin
                st_d  = ST_ADDR;
                sh_d  = addr_word(fa_q, cfg_addr4);
                cnt_d = addr_clk;
              end
              ST_ADDR: begin
                if (cfg_md_clks != '0) begin
                  st_d   = ST_MODE;
                  sh_d   = {mode_byte, 24'h0};
                  cnt_d  = CW'(cfg_md_clks);
                  mdrv_d = 4'd8 >> lg_m;
                end else begin
                  st_d  = ST_DATA;
                  cnt_d = data_clk;
                end
              end
              ST_MODE: begin
                st_d  = ST_DATA;
                cnt_d = data_clk;
              end
              default: begin
                st_d   = ST_DONE;
                rsp_d  = packed_data;
                rsp_en = 1'b1;
                if (cfg_md_clks != '0) xip_d = cfg_xip_en;
              end
            endcase
          end
        end
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      mdrv_q <= '0;
      xip_q  <= 1'b0;
      sz_q   <= '0;
      fa_q   <= '0;
      rsp_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      mdrv_q <= mdrv_d;
      xip_q  <= xip_d;
      sz_q   <= sz_d;
      fa_q   <= fa_d;
      if (rsp_en) rsp_q <= rsp_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_done  = (st_q == ST_DONE);
  assign rsp_data  = rsp_q;
  assign spi_sclk  = active && ph_q;
  assign spi_cs_n  = !active;
endmodule

// File: rtl/xip_reader_checks.sv
module xip_reader_checks #(
  parameter int          AW       = 32,
  parameter logic [31:0] WIN_BASE = 32'h0008_0000,
  parameter int          WIN_BITS = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_done,
  input logic [31:0]   rsp_data,
  input logic          spi_sclk,
  input logic          spi_cs_n,
  input logic [3:0]    spi_io_oe
);
  logic [AW-1:0] win_off;
  logic          miss;
  always_comb begin
    win_off = req_addr - AW'(WIN_BASE);
    miss    = (win_off[AW-1:WIN_BITS] != '0);
  end

  assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && miss) |=> (rsp_done && (rsp_data == 32'h0) && spi_cs_n));

  assert_oe_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_io_oe == 4'b0000) || (spi_io_oe == 4'b0001) || (spi_io_oe == 4'b0011) || (spi_io_oe == 4'b1111));

  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (!spi_sclk && (spi_io_oe == 4'b0000)));

  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  assert_sclk_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |=> $fell(spi_sclk));

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (spi_cs_n && !rsp_done));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind xip_flash_reader xip_reader_checks #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS)) u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_done(rsp_done), .rsp_data(rsp_data),
  .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_io_oe(spi_io_oe)
);

// File: tb/tb_xip_flash_reader.sv
`timescale 1ns/1ps
module tb_xip_flash_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_done;
  logic [31:0] rsp_data;
  logic [31:0] cfg_base = '0;
  logic        cfg_addr4 = 1'b0;
  logic [7:0]  cfg_cmd = 8'h0B;
  logic [1:0]  cfg_addr_lanes = '0, cfg_md_lanes = '0, cfg_data_lanes = '0;
  logic [3:0]  cfg_md_clks = 4'd8;
  logic        cfg_xip_en = 1'b0;
  logic [7:0]  cfg_mode_act = 8'hA5, cfg_mode_term = 8'hF0;
  logic        spi_sclk, spi_cs_n;
  logic [3:0]  spi_io_o, spi_io_oe;
  logic [3:0]  spi_io_i = '0;

  int tests = 0, fails = 0;
  bit xip_m = 1'b0;

  always #4 clk = ~clk;

  xip_flash_reader dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .cfg_base(cfg_base), .cfg_addr4(cfg_addr4), .cfg_cmd(cfg_cmd),
    .cfg_addr_lanes(cfg_addr_lanes), .cfg_md_lanes(cfg_md_lanes), .cfg_data_lanes(cfg_data_lanes),
    .cfg_md_clks(cfg_md_clks), .cfg_xip_en(cfg_xip_en), .cfg_mode_act(cfg_mode_act),
    .cfg_mode_term(cfg_mode_term), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe), .spi_io_i(spi_io_i)
  );

  // ---------------- flash model ----------------
  logic [3:0] exp_o [0:127];
  logic [3:0] exp_oe[0:127];
  logic [3:0] cap_o [0:127];
  logic [3:0] cap_oe[0:127];
  logic [3:0] resp  [0:31];
  int ne = 0, hdr = 0, nclk = 0, redge = 0;

  always @(negedge spi_cs_n) redge = 0;

  always @(posedge spi_sclk) begin
    if (redge < 128) begin
      cap_o[redge]  = spi_io_o;
      cap_oe[redge] = spi_io_oe;
    end
    redge = redge + 1;
  end

  always @(negedge spi_sclk) begin : drive_data
    int idx;
    idx = redge - hdr;
    if (!spi_cs_n && idx >= 0 && idx < nclk) begin
      #1 spi_io_i = resp[idx];
    end
  end

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'h5C;
  endfunction

  function automatic int lgof(input logic [1:0] s);
    return (s == 2'd0) ? 0 : (s == 2'd1) ? 1 : 2;
  endfunction

  task automatic chk(input string tag, input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // append nbits of val, MSB first, lg = log2(lanes)
  task automatic push(input logic [31:0] val, input int nbits, input int lg, input bit drv);
    int l = 1 << lg;
    for (int c = 0; c < nbits / l; c++) begin
      logic [3:0] v = 4'h0;
      for (int b = 0; b < l; b++) v[l-1-b] = val[nbits - 1 - c*l - b];
      exp_o[ne]  = v;
      exp_oe[ne] = drv ? 4'((1 << l) - 1) : 4'h0;
      ne++;
    end
  endtask

  task automatic push_idle(input int n);
    for (int c = 0; c < n; c++) begin
      exp_o[ne] = 4'h0; exp_oe[ne] = 4'h0; ne++;
    end
  endtask

  task automatic do_read(input string tag, input logic [31:0] addr, input logic [1:0] size);
    int lga = lgof(cfg_addr_lanes), lgm = lgof(cfg_md_lanes), lgd = lgof(cfg_data_lanes);
    int n = 1 << size, ld = 1 << lgd, cs_low = 0, bad = -1, guard = 0;
    logic [31:0] fa = addr - 32'h0008_0000 + cfg_base;
    logic [31:0] ds = '0, expd = '0;
    ne = 0;
    if (!xip_m) push({24'h0, cfg_cmd}, 8, 0, 1'b1);
    push(fa, cfg_addr4 ? 32 : 24, lga, 1'b1);
    if (cfg_md_clks != 0) begin
      push({24'h0, cfg_xip_en ? cfg_mode_act : cfg_mode_term}, 8, lgm, 1'b1);
      push_idle(int'(cfg_md_clks) - (8 >> lgm));
    end
    hdr  = ne;
    nclk = n * 8 / ld;
    for (int k = 0; k < n; k++) begin
      ds   = (ds << 8) | {24'h0, fbyte(fa + k)};
      expd = expd | ({24'h0, fbyte(fa + k)} << (8 * k));
    end
    for (int j = 0; j < nclk; j++) begin
      logic [3:0] v = 4'h0;
      for (int b = 0; b < ld; b++) v[ld-1-b] = ds[n*8 - 1 - j*ld - b];
      resp[j] = (ld == 1) ? {2'b00, v[0], 1'b0} : v;
    end
    push_idle(nclk);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_size = size;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && guard < 2000) begin
      if (!spi_cs_n) cs_low++;
      guard++;
      @(negedge clk);
    end
    chk(tag, rsp_data == expd, "read data (R8)", rsp_data, expd);
    for (int i = 0; i < ne; i++)
      if (bad < 0 && (cap_oe[i] != exp_oe[i] || ((cap_o[i] ^ exp_o[i]) & exp_oe[i]) != 4'h0)) bad = i;
    chk(tag, redge == ne, "serial clock count (R9)", redge, ne);
    chk(tag, bad < 0, "clock with wrong lanes/value/enable", bad < 0 ? 0 : {cap_oe[bad], 24'h0, cap_o[bad]},
        bad < 0 ? 0 : {exp_oe[bad], 24'h0, exp_o[bad]});
    chk(tag, cs_low == 2 * ne, "chip select low cycles (R9)", cs_low, 2 * ne);
    if (cfg_md_clks != 0) xip_m = cfg_xip_en;
  endtask

  task automatic t_reset;
    chk("R10", spi_cs_n && !spi_sclk && spi_io_oe == 4'h0, "idle lines after reset", {spi_cs_n, spi_sclk, spi_io_oe}, 6'b100000);
    chk("R10", req_ready && !rsp_done, "ready/done after reset", {req_ready, rsp_done}, 2'b10);
  endtask

  task automatic t_single;
    cfg_base = '0; cfg_addr4 = 0; cfg_addr_lanes = 0; cfg_md_lanes = 0; cfg_data_lanes = 0;
    cfg_md_clks = 4'd8; cfg_xip_en = 0;
    do_read("R2 R3 R4 R5 R8 single word", 32'h0008_1234, 2'd2);
  endtask

  task automatic t_quad_remap;
    cfg_base = 32'h0200_0000; cfg_addr4 = 1; cfg_addr_lanes = 2; cfg_md_lanes = 2; cfg_data_lanes = 2;
    cfg_md_clks = 4'd6; cfg_xip_en = 0;
    do_read("R2 R3 R4 R5 R8 quad half remap", 32'h000F_FF02, 2'd1);
  endtask

  task automatic t_dual_edge;
    cfg_base = 32'h0000_0100; cfg_addr4 = 0; cfg_addr_lanes = 1; cfg_md_lanes = 0; cfg_data_lanes = 1;
    cfg_md_clks = 4'd0;
    do_read("R1 R4 R5 R8 dual byte top of window", 32'h0017_FFFF, 2'd0);
  endtask

  task automatic t_xip;
    cfg_base = 32'h0001_0000; cfg_addr4 = 0; cfg_addr_lanes = 2; cfg_md_lanes = 2; cfg_data_lanes = 2;
    cfg_md_clks = 4'd6; cfg_xip_en = 1;
    do_read("R6 enter", 32'h0008_0040, 2'd2);
    do_read("R6 continuous no command", 32'h0008_0100, 2'd2);
    cfg_xip_en = 0;
    do_read("R7 terminate", 32'h0008_0200, 2'd1);
    do_read("R7 command again", 32'h0008_0300, 2'd0);
  endtask

  task automatic t_miss(input logic [31:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", rsp_done && rsp_data == 32'h0 && spi_cs_n, "out-of-window read",
        {rsp_done, spi_cs_n, 30'h0} | rsp_data, 32'hC000_0000);
    @(negedge clk);
    chk("R1 R10", req_ready && !rsp_done && spi_cs_n, "idle after miss", {req_ready, rsp_done, spi_cs_n}, 3'b101);
  endtask

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_single;
    t_quad_remap;
    t_dual_edge;
    t_miss(32'h0007_FFFF);
    t_miss(32'h0018_0000);
    t_xip;
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule